// File: doc/BRIEF.md
# Privilege-Masked Flags Restore Unit

This block commits a value taken off the stack into the processor's flags register. The popped value is not simply loaded. A write mask is built for each bit from the execution mode, the current privilege level, the I/O privilege field already held in the register and the operand size. Bits the mask allows take the popped value. Every other bit keeps its old value. In virtual-8086 mode with the extension enabled and a low I/O privilege, popped bit 9 is steered into the virtual interrupt flag instead of the real one.

Some combinations are illegal. For those, the block raises a general-protection fault pulse and leaves the register exactly as it was. The resume flag is cleared by every pop that completes. Reserved positions hold fixed values whatever the popped data is.

Top module: `flags_restore_unit`

## Requirements
- R1: After reset `flags_q` equals the `RESET_FLAGS` parameter, which defaults to 0x2, and `gp_fault` is low.
- R2: Bit 1 of `flags_q` is always 1. Bits 3, 5, 15 and 22 and above are always 0, whatever the popped data.
- R3: Every completed pop clears bit 16. Bits 17 (VM), 19 (VIF) and 20 (VIP) are never copied from the same popped bit.
- R4: With a 16-bit operand size (`op_size` = 0), only bits 15:0 can take popped data. Bits 18 and 21 keep their old values.
- R5: In real mode (`mode` = 0), and in protected/long mode (`mode` = 1) with `cpl` = 0, pop data is written into bits 0, 2, 4, 6–11, 12–13 and 14. For wider operand sizes, bits 18 and 21 are written as well.
- R6: In protected/long mode with `cpl` > 0, bits 13:12 are kept. Bit 9 is written only when `cpl` ≤ the held bits 13:12. No fault is raised in this mode.
- R7: In virtual-8086 mode without the extension (`mode` = 2), a pop faults when the held bits 13:12 are not 3. When they are 3, the pop writes the low arithmetic and control flags, bit 9 and bit 14, and keeps bits 13:12, 17, 19 and 20. Virtual-8086 mode with the extension (`mode` = 3) behaves the same way when the held bits 13:12 equal 3.
- R8: In `mode` = 3 with the held bits 13:12 below 3, a 32-bit or 64-bit pop faults.
- R9: In `mode` = 3 with the held bits 13:12 below 3, a 16-bit pop faults if held bit 20 is 1 and popped bit 9 is 1. Otherwise, popped bit 9 goes to bit 19, bits 9 and 13:12 are kept, and the other low non-reserved bits are written.
- R10: A 64-bit pop (`op_size` = 2) follows the 32-bit mask, and bits 63:32 do not change.
- R11: The register changes only on an edge where `pop_valid` is high and no fault arises. `gp_fault` is high for exactly the one cycle that follows a faulting pop, and a faulting pop changes nothing.
- R12: The `op_size` encoding is 0 for 16-bit, 1 for 32-bit and 2 for 64-bit. The value 3 is treated as 64-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pop_valid | input | 1 | A popped value is presented this cycle |
| pop_data | input | FLAG_W | The popped stack value |
| mode | input | 2 | 0 real, 1 protected/long, 2 virtual-8086, 3 virtual-8086 with extension |
| cpl | input | 2 | Current privilege level |
| op_size | input | 2 | Operand size code |
| flags_q | output | FLAG_W | Flags register |
| gp_fault | output | 1 | One-cycle general-protection fault pulse |

## Verification
Both results of a pop, the new `flags_q` and the `gp_fault` pulse, are registered. Each is due on the first rising edge after the cycle in which `pop_valid` is presented, and is visible from then on. The bench drives each pop at a falling edge and samples both outputs at the next falling edge, one edge later. Against that sample it compares the values its own model predicts for every mode, privilege, I/O-privilege and size combination. A second instance resets with bit 20 set, which reaches the fault case of R9. Idle cycles sampled at the same offset confirm that the pulse has dropped and that the register holds.

// File: rtl/frest_pkg.sv
package frest_pkg;

   localparam int B_CF   = 0;
   localparam int B_PF   = 2;
   localparam int B_AF   = 4;
   localparam int B_ZF   = 6;
   localparam int B_SF   = 7;
   localparam int B_TF   = 8;
   localparam int B_IF   = 9;
   localparam int B_DF   = 10;
   localparam int B_OF   = 11;
   localparam int B_IOLO = 12;
   localparam int B_IOHI = 13;
   localparam int B_NT   = 14;
   localparam int B_RF   = 16;
   localparam int B_VM   = 17;
   localparam int B_AC   = 18;
   localparam int B_VIF  = 19;
   localparam int B_VIP  = 20;
   localparam int B_ID   = 21;
   localparam int B_ONE  = 1;

   // architecturally defined (non-reserved) positions
   localparam logic [63:0] ARCH_MASK  = 64'h0000_0000_003F_7FD5;
   localparam logic [63:0] LOW_MASK   = 64'h0000_0000_0000_FFFF;
   // never loaded straight from the popped bit at the same position
   localparam logic [63:0] STRIP_MASK = (64'd1 << B_RF) | (64'd1 << B_VM) |
                                        (64'd1 << B_VIF) | (64'd1 << B_VIP);
   localparam logic [63:0] IOPL_MASK  = (64'd1 << B_IOLO) | (64'd1 << B_IOHI);
   localparam logic [63:0] IF_MASK    = 64'd1 << B_IF;

   typedef enum logic [1:0] {
      MODE_REAL = 2'd0,
      MODE_PROT = 2'd1,
      MODE_V86  = 2'd2,
      MODE_V86X = 2'd3
   } exec_mode_e;

   typedef enum logic [1:0] {
      OPS_16  = 2'd0,
      OPS_32  = 2'd1,
      OPS_64  = 2'd2,
      OPS_64B = 2'd3
   } op_size_e;

endpackage

// File: rtl/frest_policy.sv
module frest_policy
   import frest_pkg::*;
#(
   parameter int FLAG_W = 64
) (
   input  exec_mode_e          mode,
   input  logic [1:0]          cpl,
   input  op_size_e            op_size,
   input  logic [1:0]          cur_iopl,
   input  logic                cur_vip,
   input  logic                pop_if,
   output logic [FLAG_W-1:0]   wr_mask,
   output logic                vif_take,
   output logic                fault
);

   localparam logic [FLAG_W-1:0] WIDE_BASE = FLAG_W'(ARCH_MASK & ~STRIP_MASK);
   localparam logic [FLAG_W-1:0] NARROW_BASE = FLAG_W'(ARCH_MASK & LOW_MASK & ~STRIP_MASK);
   localparam logic [FLAG_W-1:0] IOPL_W = FLAG_W'(IOPL_MASK);
   localparam logic [FLAG_W-1:0] IF_W   = FLAG_W'(IF_MASK);

   logic                wide;
   logic [FLAG_W-1:0]   m;
   logic                f;
   logic                redirect;

   assign wide = (op_size != OPS_16);

   always_comb begin
      m        = wide ? WIDE_BASE : NARROW_BASE;
      f        = 1'b0;
      redirect = 1'b0;
      unique case (mode)
         MODE_REAL: ;
         MODE_PROT: begin
            if (cpl != 2'd0) begin
               m = m & ~IOPL_W;
               if (cpl > cur_iopl) m = m & ~IF_W;
            end
         end
         MODE_V86: begin
            if (cur_iopl != 2'd3) f = 1'b1;
            else                  m = m & ~IOPL_W;
         end
         MODE_V86X: begin
            if (cur_iopl == 2'd3)          m = m & ~IOPL_W;
            else if (wide)                 f = 1'b1;
            else if (cur_vip && pop_if)    f = 1'b1;
            else begin
               m        = m & ~(IOPL_W | IF_W);
               redirect = 1'b1;
            end
         end
         default: ;
      endcase
      wr_mask  = f ? '0 : m;
      vif_take = redirect & ~f;
      fault    = f;
   end

endmodule

// File: rtl/frest_merge.sv
module frest_merge
   import frest_pkg::*;
#(
   parameter int FLAG_W = 64
) (
   input  logic [FLAG_W-1:0] cur,
   input  logic [FLAG_W-1:0] pop_data,
   input  logic [FLAG_W-1:0] wr_mask,
   input  logic              vif_take,
   output logic [FLAG_W-1:0] nxt
);

   logic [FLAG_W-1:0] used_pos;

   for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
      if (i == B_ONE) begin : g_one
         assign nxt[i]      = 1'b1;
         assign used_pos[i] = 1'b0;
      end else if (!ARCH_MASK[i]) begin : g_resv
         assign nxt[i]      = 1'b0;
         assign used_pos[i] = 1'b0;
      end else if (i == B_RF) begin : g_rf
         assign nxt[i]      = 1'b0;
         assign used_pos[i] = 1'b0;
      end else if (i == B_VIF) begin : g_vif
         assign nxt[i]      = vif_take ? pop_data[B_IF] : cur[i];
         assign used_pos[i] = 1'b1;
      end else begin : g_norm
         assign nxt[i]      = wr_mask[i] ? pop_data[i] : cur[i];
         assign used_pos[i] = 1'b1;
      end
   end

   logic unused_bits;
   assign unused_bits = ^((cur | pop_data | wr_mask) & ~used_pos);

endmodule

// File: rtl/frest_state.sv
module frest_state #(
   parameter int                 FLAG_W      = 64,
   parameter logic [FLAG_W-1:0]  RESET_FLAGS = FLAG_W'(2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              fault_in,
   input  logic [FLAG_W-1:0] nxt,
   output logic [FLAG_W-1:0] flags_q,
   output logic              fault_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= RESET_FLAGS;
         fault_q <= 1'b0;
      end else begin
         fault_q <= fault_in;
         if (load) flags_q <= nxt;
      end
   end

   // R11
   fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q |-> flags_q == $past(flags_q));

endmodule

// File: rtl/flags_restore_unit.sv
module flags_restore_unit
   import frest_pkg::*;
#(
   parameter int                 FLAG_W      = 64,
   parameter logic [FLAG_W-1:0]  RESET_FLAGS = FLAG_W'(2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pop_valid,
   input  logic [FLAG_W-1:0] pop_data,
   input  logic [1:0]        mode,
   input  logic [1:0]        cpl,
   input  logic [1:0]        op_size,
   output logic [FLAG_W-1:0] flags_q,
   output logic              gp_fault
);

   localparam logic [FLAG_W-1:0] ARCH_W = FLAG_W'(ARCH_MASK);
   localparam logic [FLAG_W-1:0] ONE_W  = FLAG_W'(1) << B_ONE;

   if (FLAG_W < 32 || FLAG_W > 64) begin : g_bad_width
      $error("flags_restore_unit: FLAG_W must lie in 32..64");
   end
   if ((RESET_FLAGS & ~ARCH_W) != ONE_W) begin : g_bad_reset
      $error("flags_restore_unit: RESET_FLAGS must hold reserved bits at fixed values");
   end
   if (RESET_FLAGS[B_RF] || RESET_FLAGS[B_VM]) begin : g_bad_reset_rf
      $error("flags_restore_unit: RESET_FLAGS must have RF and VM clear");
   end

   logic [FLAG_W-1:0] wr_mask;
   logic [FLAG_W-1:0] nxt;
   logic              vif_take;
   logic              fault;
   exec_mode_e        mode_e;
   op_size_e          size_e;

   assign mode_e = exec_mode_e'(mode);
   assign size_e = op_size_e'(op_size);

   frest_policy #(.FLAG_W(FLAG_W)) u_policy (
      .mode     (mode_e),
      .cpl      (cpl),
      .op_size  (size_e),
      .cur_iopl (flags_q[B_IOHI:B_IOLO]),
      .cur_vip  (flags_q[B_VIP]),
      .pop_if   (pop_data[B_IF]),
      .wr_mask  (wr_mask),
      .vif_take (vif_take),
      .fault    (fault)
   );

   frest_merge #(.FLAG_W(FLAG_W)) u_merge (
      .cur      (flags_q),
      .pop_data (pop_data),
      .wr_mask  (wr_mask),
      .vif_take (vif_take),
      .nxt      (nxt)
   );

   frest_state #(.FLAG_W(FLAG_W), .RESET_FLAGS(RESET_FLAGS)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (pop_valid & ~fault),
      .fault_in (pop_valid & fault),
      .nxt      (nxt),
      .flags_q  (flags_q),
      .fault_q  (gp_fault)
   );

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_valid |=> $stable(flags_q));

   // R11
   pulse_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_valid |=> !gp_fault);

   // R3
   rf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid |=> !flags_q[B_RF]);

   // R2
   reserved_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q & ~ARCH_W) == ONE_W);

   // R6
   prot_iopl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_valid && mode == 2'd1 && cpl != 2'd0) |=>
         (flags_q[B_IOHI:B_IOLO] == $past(flags_q[B_IOHI:B_IOLO])) && !gp_fault);

   // R7
   v86_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_valid && mode == 2'd2 && flags_q[B_IOHI:B_IOLO] != 2'd3) |=> gp_fault);

   // R3
   vm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid |=> $stable(flags_q[B_VM]) && $stable(flags_q[B_VIP]));

endmodule

// File: tb/flags_restore_unit_bench.sv
`timescale 1ns/1ps
module flags_restore_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pop_valid = 1'b0;
   logic [63:0] pop_data = '0;
   logic [1:0]  mode = '0;
   logic [1:0]  cpl = '0;
   logic [1:0]  op_size = '0;
   logic [63:0] flags_a, flags_b;
   logic        gp_a, gp_b;

   int n_checks = 0;
   int n_fail = 0;
   logic [63:0] exp_a, exp_b;

   always #10 clk = ~clk;

   flags_restore_unit u_flags_restore_unit (
      .clk(clk), .rst_n(rst_n), .pop_valid(pop_valid), .pop_data(pop_data),
      .mode(mode), .cpl(cpl), .op_size(op_size), .flags_q(flags_a), .gp_fault(gp_a));

   flags_restore_unit #(.RESET_FLAGS(64'h0000_0000_0010_0002)) u_flags_restore_unit_vip (
      .clk(clk), .rst_n(rst_n), .pop_valid(pop_valid), .pop_data(pop_data),
      .mode(mode), .cpl(cpl), .op_size(op_size), .flags_q(flags_b), .gp_fault(gp_b));

   // model: {fault, new flags} from the requirement text
   function automatic logic [64:0] ref_step(input logic [63:0] old, input logic [63:0] d,
                                            input logic [1:0] md, input logic [1:0] cp,
                                            input logic [1:0] os);
      logic [63:0] n;
      logic        f;
      logic        w;
      logic [1:0]  io;
      int          plain [9] = '{0, 2, 4, 6, 7, 8, 10, 11, 14};
      n  = old;
      w  = (os != 2'd0);
      io = old[13:12];
      f  = (md == 2'd2 && io != 2'd3) ||
           (md == 2'd3 && io != 2'd3 && (w || (old[20] && d[9])));
      if (!f) begin
         foreach (plain[k]) n[plain[k]] = d[plain[k]];
         if (md == 2'd0 || (md == 2'd1 && cp <= io) || (md >= 2'd2 && io == 2'd3))
            n[9] = d[9];
         if (md == 2'd0 || (md == 2'd1 && cp == 2'd0))
            n[13:12] = d[13:12];
         if (w) begin
            n[18] = d[18];
            n[21] = d[21];
         end
         if (md == 2'd3 && io != 2'd3) n[19] = d[9];
         n[16] = 1'b0;
      end
      return {f, n};
   endfunction

   function automatic string tag_of(input logic [63:0] old, input logic [1:0] md,
                                    input logic [1:0] cp, input logic [1:0] os);
      if (md == 2'd3 && old[13:12] != 2'd3) return (os != 2'd0) ? "R8" : "R9";
      if (md >= 2'd2) return "R7";
      if (md == 2'd1 && cp != 2'd0) return "R6";
      if (os == 2'd0) return "R4";
      if (os[1]) return "R10";
      return "R5";
   endfunction

   task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s flags actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check1(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s fault actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic do_pop(input logic [1:0] md, input logic [1:0] cp, input logic [1:0] os,
                         input logic [63:0] d, input string tag_in);
      logic [64:0] ra, rb;
      string ta, tb;
      @(negedge clk);
      ta = (tag_in == "") ? tag_of(exp_a, md, cp, os) : tag_in;
      tb = (tag_in == "") ? tag_of(exp_b, md, cp, os) : tag_in;
      ra = ref_step(exp_a, d, md, cp, os);
      rb = ref_step(exp_b, d, md, cp, os);
      mode = md; cpl = cp; op_size = os; pop_data = d; pop_valid = 1'b1;
      @(negedge clk);
      pop_valid = 1'b0;
      exp_a = ra[63:0];
      exp_b = rb[63:0];
      check64(ta, flags_a, exp_a);
      check1(ta, gp_a, ra[64]);
      check64(tb, flags_b, exp_b);
      check1(tb, gp_b, rb[64]);
   endtask

   task automatic do_idle(input string tag);
      @(negedge clk);
      pop_data = {$urandom, $urandom};
      mode = 2'($urandom); cpl = 2'($urandom); op_size = 2'($urandom);
      @(negedge clk);
      check64(tag, flags_a, exp_a);
      check1(tag, gp_a, 1'b0);
      check64(tag, flags_b, exp_b);
      check1(tag, gp_b, 1'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      exp_a = 64'h2;
      exp_b = 64'h0010_0002;
      @(negedge clk);
      // R1 reset state
      check64("R1", flags_a, 64'h2);
      check1("R1", gp_a, 1'b0);
      check64("R1", flags_b, 64'h0010_0002);

      // R5 and R2: full pop at privilege 0
      do_pop(2'd1, 2'd0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
      check64("R2", flags_a, 64'h0000_0000_0024_7FD7);
      // R4: narrow pop keeps AC and ID
      do_pop(2'd0, 2'd3, 2'd0, 64'h0, "R4");
      check64("R4", flags_a, 64'h0000_0000_0024_0002);
      // R6: IF kept when privilege is below the I/O level
      do_pop(2'd1, 2'd0, 2'd1, 64'h0200, "R6");
      do_pop(2'd1, 2'd2, 2'd1, 64'h0000_3000, "R6");
      check64("R6", flags_a, 64'h0000_0000_0000_0202);
      // R7: virtual-8086 with low I/O level faults, then pulse drops
      do_pop(2'd2, 2'd3, 2'd0, 64'hFFFF, "R7");
      check1("R7", gp_a, 1'b1);
      do_idle("R11");
      // R8: extension, wide pop faults
      do_pop(2'd3, 2'd3, 2'd1, 64'h0, "R8");
      check1("R8", gp_a, 1'b1);
      // R9: redirect into VIF (instance a) and fault with VIP held (instance b)
      do_pop(2'd3, 2'd3, 2'd0, 64'h0000_0000_0000_0200, "R9");
      check64("R9", flags_a, 64'h0000_0000_0008_0202);
      check1("R9", gp_b, 1'b1);
      do_pop(2'd3, 2'd3, 2'd0, 64'h0000_0000_0000_08C1, "R9");
      // R7: I/O level 3 in both virtual-8086 variants
      do_pop(2'd0, 2'd0, 2'd1, 64'h0000_3000, "R7");
      do_pop(2'd2, 2'd3, 2'd1, 64'hFFFF_FFFF, "R7");
      do_pop(2'd3, 2'd3, 2'd0, 64'h0000_0000_0000_0000, "R7");
      // R10 and R12: 64-bit and code 3
      do_pop(2'd1, 2'd0, 2'd2, 64'hFFFF_FFFF_0000_0000, "R10");
      check64("R10", flags_a[63:32], 64'h0);
      do_pop(2'd1, 2'd0, 2'd3, 64'h0000_0000_0024_0000, "R12");
      do_idle("R11");
      // R3: RF never set
      check1("R3", flags_a[16], 1'b0);

      for (int i = 0; i < 1500; i++) begin
         logic [63:0] d;
         d = {$urandom, $urandom};
         if ($urandom_range(0, 9) == 0) do_idle("R11");
         else do_pop(2'($urandom), 2'($urandom), 2'($urandom), d, "");
         if (i % 200 == 0) do_pop(2'd0, 2'd0, 2'd1, d & ~64'h0000_3000, "R5");
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule